// File: doc/BRIEF.md
# Indexed-Register Watchdog Timer

This block is a watchdog timer that software programs through an index/data port pair on an 8-bit I/O bus. A write to the index port picks a register, and the following read or write of the data port reaches that register. The timeout count is a 24-bit value spread over three byte registers. The counter runs down on a slow tick strobe of about 30.5 µs per tick (32.768 kHz), so the longest period is about 512 s.

The configuration registers are guarded by a key. The key register takes one value that opens the registers and another that closes them. While the registers are closed, writes to them are dropped, but they can still be read. When the count runs out, the block sets a sticky timeout flag and fires one action: a fixed-length system-reset pulse, a fixed-length NMI pulse, or a level interrupt request. A control bit enables counting. Software kicks the timer by writing the status register, which reloads the count and clears the flag.

Top module: `idx_watchdog`

## Requirements
- R1: A write with `bus_addr`=0 stores the register index, and a read with `bus_addr`=0 returns that index. A read with `bus_addr`=1 returns the selected register, an index that names no register reads 00h, and `bus_rdata` is 00h whenever `bus_rd` is low.
- R2: After reset the registers are locked. Writing C5h to index 13h unlocks them and writing 00h to index 13h locks them again. Any other value written to 13h leaves the lock state as it was.
- R3: While locked, data-port writes to indices 37h through 3Ch change nothing, and reads of those indices still return the stored values.
- R4: Index 37h stores all 8 bits written and reads them back. Its bit 6 enables counting: with bit 6 at 0, ticks never cause a timeout, and a write that changes bit 6 from 0 to 1 reloads the count.
- R5: The 24-bit load value is split across index 39h (bits 7:0), 3Ah (bits 15:8) and 3Bh (bits 23:16), and each byte reads back as written.
- R6: After a reload, the timeout happens on the N-th tick taken while enabled, where N is the load value. A load value of 0 times out on the first tick.
- R7: Index 38h stores all 8 bits written. Its bits 7:4 choose the action: 1101 gives a system-reset pulse, 1011 gives an NMI pulse, and any other code gives an interrupt request.
- R8: A reset or NMI pulse rises on the clock edge that takes the expiring tick and stays high for exactly PULSE_CYCLES (16) clocks.
- R9: An interrupt request stays high after a timeout until a kick clears it.
- R10: Index 3Ch reads back the timeout flag in bit 6 and 0 in every other bit. A write with bit 6 at 1 clears the flag and reloads the count. A write with bit 6 at 0 does nothing.
- R11: After a timeout the counter stops, and further ticks cause no new action until a kick or a fresh enable.
- R12: At most one of `sys_rst_pulse`, `nmi_pulse` and `irq_req` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-clock timebase strobe (one tick per count) |
| bus_wr | input | 1 | Bus write strobe, one clock per access |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | 1 | 0 = index port, 1 = data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the selected register |
| sys_rst_pulse | output | 1 | System-reset action pulse |
| nmi_pulse | output | 1 | NMI action pulse |
| irq_req | output | 1 | Interrupt-request action level |

## Verification
A wrong count or a missed reload shows up on the action outputs as a timeout that comes one or more ticks too early or too late. The bench counts ticks one at a time for small loads and for a load of 65537, so an error in the middle or top byte also appears. A lock that leaks shows up on the next read of a load byte, which no longer matches the value stored before the locked write. A wrong action decode or pulse length is visible within 16 clocks of the expiring tick, because the bench sweeps all sixteen action codes and measures each pulse.

// File: rtl/idx_wdt_pkg.sv
`timescale 1ns/1ps
package idx_wdt_pkg;
   // Indices whose values software depends on
   localparam logic [7:0] IDX_KEY   = 8'h13;
   localparam logic [7:0] KEY_OPEN  = 8'hC5;
   localparam logic [7:0] KEY_CLOSE = 8'h00;
   localparam logic [7:0] IDX_CTRL  = 8'h37;
   localparam logic [7:0] IDX_ACT   = 8'h38;
   localparam logic [7:0] IDX_LOAD0 = 8'h39;
   localparam int         EN_BIT    = 6;
   localparam int         FLAG_BIT  = 6;

   typedef enum logic [1:0] {FIRE_IRQ, FIRE_RESET, FIRE_NMI} fire_e;

   function automatic fire_e decode_fire(input logic [3:0] code);
      case (code)
         4'b1101: return FIRE_RESET;
         4'b1011: return FIRE_NMI;
         default: return FIRE_IRQ;
      endcase
   endfunction
endpackage

// File: rtl/idx_wdt_regs.sv
`timescale 1ns/1ps
module idx_wdt_regs
   import idx_wdt_pkg::*;
#(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic             bus_addr,
   input  logic [7:0]       bus_wdata,
   output logic [7:0]       bus_rdata,
   input  logic             expire,
   output logic             unlocked,
   output logic             enable,
   output logic [3:0]       act_code,
   output logic [CNT_W-1:0] load_val,
   output logic             reload,
   output logic             kick,
   output logic             to_flag
);
   localparam int         NB         = CNT_W / 8;
   localparam logic [7:0] IDX_STATUS = 8'(IDX_LOAD0 + NB);

   logic [7:0] idx_q;
   logic [7:0] ctrl_q;
   logic [7:0] act_q;
   logic [7:0] load_q [NB];
   logic [7:0] rd_mux;
   logic       data_wr;
   logic       cfg_wr;
   logic       en_rise;

   assign data_wr = bus_wr && bus_addr;
   assign cfg_wr  = data_wr && unlocked;
   assign en_rise = cfg_wr && (idx_q == IDX_CTRL) && bus_wdata[EN_BIT] && !ctrl_q[EN_BIT];
   assign kick    = cfg_wr && (idx_q == IDX_STATUS) && bus_wdata[FLAG_BIT];
   assign reload  = en_rise || kick;
   assign enable  = ctrl_q[EN_BIT];
   assign act_code = act_q[7:4];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q    <= '0;
         unlocked <= 1'b0;
         ctrl_q   <= '0;
         act_q    <= '0;
         to_flag  <= 1'b0;
      end else begin
         if (bus_wr && !bus_addr) idx_q <= bus_wdata;
         if (data_wr && idx_q == IDX_KEY) begin
            if (bus_wdata == KEY_OPEN)       unlocked <= 1'b1;
            else if (bus_wdata == KEY_CLOSE) unlocked <= 1'b0;
         end
         if (cfg_wr && idx_q == IDX_CTRL) ctrl_q <= bus_wdata;
         if (cfg_wr && idx_q == IDX_ACT)  act_q  <= bus_wdata;
         if (kick)        to_flag <= 1'b0;
         else if (expire) to_flag <= 1'b1;
      end
   end

   for (genvar b = 0; b < NB; b++) begin : g_load
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            load_q[b] <= '0;
         else if (cfg_wr && idx_q == 8'(IDX_LOAD0 + b))
            load_q[b] <= bus_wdata;
      end
      assign load_val[b*8 +: 8] = load_q[b];
   end

   always_comb begin
      rd_mux = '0;
      if (!bus_addr) begin
         rd_mux = idx_q;
      end else begin
         if (idx_q == IDX_CTRL)   rd_mux = ctrl_q;
         if (idx_q == IDX_ACT)    rd_mux = act_q;
         if (idx_q == IDX_STATUS) rd_mux = 8'(to_flag) << FLAG_BIT;
         for (int b = 0; b < NB; b++)
            if (idx_q == 8'(IDX_LOAD0 + b)) rd_mux = load_q[b];
      end
   end

   assign bus_rdata = bus_rd ? rd_mux : '0;
endmodule

// File: rtl/idx_wdt_count.sv
`timescale 1ns/1ps
module idx_wdt_count #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             reload,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   output logic             expire
);
   logic [CNT_W-1:0] cnt_q;
   logic             run_q;

   // zero and one both mean "expire on the next tick"
   assign expire = enable && run_q && tick && !reload && (cnt_q <= CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (reload) begin
         cnt_q <= load_val;
         run_q <= 1'b1;
      end else if (expire) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (enable && run_q && tick) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end
endmodule

// File: rtl/idx_wdt_fire.sv
`timescale 1ns/1ps
module idx_wdt_fire
   import idx_wdt_pkg::*;
#(
   parameter int PULSE_CYCLES = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       expire,
   input  logic [3:0] act_code,
   input  logic       clear_irq,
   output logic       sys_rst_pulse,
   output logic       nmi_pulse,
   output logic       irq_req
);
   localparam int PW = $clog2(PULSE_CYCLES + 1);

   fire_e         kind_q;
   fire_e         sel;
   logic [PW-1:0] pcnt_q;

   assign sel = decode_fire(act_code);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q  <= FIRE_IRQ;
         pcnt_q  <= '0;
         irq_req <= 1'b0;
      end else if (expire) begin
         kind_q <= sel;
         if (sel == FIRE_IRQ) begin
            pcnt_q  <= '0;
            irq_req <= 1'b1;
         end else begin
            pcnt_q  <= PW'(PULSE_CYCLES);
            irq_req <= 1'b0;
         end
      end else begin
         if (pcnt_q != '0) pcnt_q <= pcnt_q - PW'(1);
         if (clear_irq) irq_req <= 1'b0;
      end
   end

   assign sys_rst_pulse = (pcnt_q != '0) && (kind_q == FIRE_RESET);
   assign nmi_pulse     = (pcnt_q != '0) && (kind_q == FIRE_NMI);
endmodule

// File: rtl/idx_watchdog.sv
`timescale 1ns/1ps
module idx_watchdog #(
   parameter int CNT_W        = 24,
   parameter int PULSE_CYCLES = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       bus_wr,
   input  logic       bus_rd,
   input  logic       bus_addr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   output logic       sys_rst_pulse,
   output logic       nmi_pulse,
   output logic       irq_req
);
   if (CNT_W % 8 != 0 || CNT_W < 8 || CNT_W > 32) begin : g_bad_width
      $error("CNT_W must be a multiple of 8 between 8 and 32");
   end
   if (PULSE_CYCLES < 1) begin : g_bad_pulse
      $error("PULSE_CYCLES must be at least 1");
   end

   logic             unlocked;
   logic             enable;
   logic [3:0]       act_code;
   logic [CNT_W-1:0] load_val;
   logic             reload;
   logic             kick;
   logic             to_flag;
   logic             expire;

   idx_wdt_regs #(.CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .expire(expire), .unlocked(unlocked), .enable(enable),
      .act_code(act_code), .load_val(load_val), .reload(reload),
      .kick(kick), .to_flag(to_flag)
   );

   idx_wdt_count #(.CNT_W(CNT_W)) u_count (
      .clk(clk), .rst_n(rst_n), .enable(enable), .reload(reload),
      .load_val(load_val), .tick(tick), .expire(expire)
   );

   idx_wdt_fire #(.PULSE_CYCLES(PULSE_CYCLES)) u_fire (
      .clk(clk), .rst_n(rst_n), .expire(expire), .act_code(act_code),
      .clear_irq(kick), .sys_rst_pulse(sys_rst_pulse),
      .nmi_pulse(nmi_pulse), .irq_req(irq_req)
   );
endmodule

// File: rtl/idx_wdt_check.sv
`timescale 1ns/1ps
module idx_wdt_check #(
   parameter int CNT_W        = 24,
   parameter int PULSE_CYCLES = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             bus_wr,
   input logic             bus_addr,
   input logic             unlocked,
   input logic [CNT_W-1:0] load_val,
   input logic             to_flag,
   input logic             expire,
   input logic             sys_rst_pulse,
   input logic             nmi_pulse,
   input logic             irq_req
);
   int hi_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || expire) hi_run <= 0;
      else if (sys_rst_pulse || nmi_pulse) hi_run <= hi_run + 1;
      else hi_run <= 0;
   end

   assert_single_output_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sys_rst_pulse, nmi_pulse, irq_req}));

   assert_locked_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!unlocked && bus_wr && bus_addr) |=> $stable(load_val));

   assert_flag_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(to_flag) |-> $past(tick));

   assert_pulse_has_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sys_rst_pulse) || $rose(nmi_pulse)) |-> to_flag);

   assert_pulse_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hi_run <= PULSE_CYCLES);

   assert_irq_until_kick_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_req) |-> !to_flag);
endmodule

bind idx_watchdog idx_wdt_check #(.CNT_W(CNT_W), .PULSE_CYCLES(PULSE_CYCLES)) u_check (
   .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .unlocked(unlocked), .load_val(load_val), .to_flag(to_flag), .expire(expire),
   .sys_rst_pulse(sys_rst_pulse), .nmi_pulse(nmi_pulse), .irq_req(irq_req)
);

// File: tb/idx_watchdog_bench.sv
`timescale 1ns/1ps
module idx_watchdog_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic       bus_addr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       sys_rst_pulse, nmi_pulse, irq_req;
   int         checks = 0;
   int         errors = 0;

   always #2.5 clk = ~clk;

   idx_watchdog u_idx_watchdog (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sys_rst_pulse(sys_rst_pulse), .nmi_pulse(nmi_pulse), .irq_req(irq_req)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic port_wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic wreg(input logic [7:0] idx, input logic [7:0] d);
      port_wr(1'b0, idx);
      port_wr(1'b1, d);
   endtask

   task automatic rreg(input logic [7:0] idx, output logic [7:0] d);
      port_wr(1'b0, idx);
      bus_addr = 1'b1; bus_rd = 1'b1;
      #1 d = bus_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic tick_once();
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
   endtask

   task automatic set_load(input logic [23:0] v);
      wreg(8'h39, v[7:0]);
      wreg(8'h3A, v[15:8]);
      wreg(8'h3B, v[23:16]);
   endtask

   function automatic logic [2:0] expect_kind(input logic [3:0] c);
      if (c == 4'b1101) return 3'b100;
      if (c == 4'b1011) return 3'b010;
      return 3'b001;
   endfunction

   initial begin
      #(190000 * 5);
      errors++;
      $display("FAIL watchdog timer expired, run hung");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] d;
      int         n;
      int         w;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      check("R12 reset outputs", {29'd0, sys_rst_pulse, nmi_pulse, irq_req}, 0);
      check("R1 rdata idle", bus_rdata, 0);
      rreg(8'h3C, d); check("R10 reset status", d, 0);
      port_wr(1'b0, 8'h5A);
      bus_addr = 1'b0; bus_rd = 1'b1; #1 d = bus_rdata; bus_rd = 1'b0;
      check("R1 index readback", d, 8'h5A);
      rreg(8'h70, d); check("R1 unknown index", d, 0);

      // locked after reset: writes ignored
      wreg(8'h39, 8'hAA);
      wreg(8'h13, 8'h55);           // wrong key, stays locked
      wreg(8'h39, 8'hAB);
      wreg(8'h13, 8'hC5);           // R2 open
      rreg(8'h39, d); check("R2 R3 locked write dropped", d, 0);

      // R5 load bytes
      set_load(24'h332211);
      rreg(8'h39, d); check("R5 byte0", d, 8'h11);
      rreg(8'h3A, d); check("R5 byte1", d, 8'h22);
      rreg(8'h3B, d); check("R5 byte2", d, 8'h33);

      // R4 / R7 full-byte storage
      wreg(8'h37, 8'hBF); rreg(8'h37, d); check("R4 ctrl bits kept", d, 8'hBF);
      wreg(8'h38, 8'hD7); rreg(8'h38, d); check("R7 act bits kept", d, 8'hD7);

      // R4 disabled: no timeout
      set_load(24'd2);
      wreg(8'h38, 8'h05);
      wreg(8'h37, 8'h00);
      repeat (6) tick_once();
      check("R4 disabled no irq", irq_req, 0);
      rreg(8'h3C, d); check("R4 disabled no flag", d, 0);

      // R6 tick count sweep with IRQ action
      for (int L = 0; L < 7; L++) begin
         wreg(8'h37, 8'h00);
         set_load(24'(L));
         wreg(8'h37, 8'h40);
         n = 0;
         while (!irq_req && n < 20) begin tick_once(); n++; end
         check($sformatf("R6 ticks for load %0d", L), n, (L == 0) ? 1 : L);
         rreg(8'h3C, d); check("R10 flag set", d, 8'h40);
         wreg(8'h3C, 8'h00);
         check("R10 write 0 keeps irq", irq_req, 1);
         wreg(8'h3C, 8'h40);
         check("R9 kick clears irq", irq_req, 0);
         rreg(8'h3C, d); check("R10 kick clears flag", d, 0);
      end

      // R6 large load exercising upper bytes, tick held
      wreg(8'h37, 8'h00);
      set_load(24'h010001);
      wreg(8'h37, 8'h40);
      @(negedge clk); tick = 1'b1; n = 0;
      while (!irq_req && n < 70000) begin @(negedge clk); n++; end
      tick = 1'b0;
      check("R6 ticks for load 010001h", n, 32'h10001);
      wreg(8'h3C, 8'h40);

      // R7 / R8 / R12 action sweep over all codes
      set_load(24'd2);
      for (int c = 0; c < 16; c++) begin
         wreg(8'h37, 8'h00);
         wreg(8'h38, {4'(c), 4'h5});
         wreg(8'h37, 8'h40);
         tick_once();
         check("R6 no early action", {29'd0, sys_rst_pulse, nmi_pulse, irq_req}, 0);
         tick_once();
         check($sformatf("R7 R12 action code %0d", c),
               {29'd0, sys_rst_pulse, nmi_pulse, irq_req}, {29'd0, expect_kind(4'(c))});
         if (expect_kind(4'(c)) != 3'b001) begin
            w = 0;
            while ((sys_rst_pulse || nmi_pulse) && w < 40) begin w++; @(negedge clk); end
            check($sformatf("R8 pulse width code %0d", c), w, 16);
            if (c == 13) begin
               repeat (5) tick_once();
               check("R11 no retrigger after timeout", {30'd0, sys_rst_pulse, nmi_pulse}, 0);
               rreg(8'h3C, d); check("R11 flag stays", d, 8'h40);
            end
         end else begin
            repeat (20) @(negedge clk);
            check("R9 irq held", irq_req, 1);
         end
         wreg(8'h3C, 8'h40);
      end

      // R3: locked kick ignored, reads still work
      wreg(8'h37, 8'h00);
      wreg(8'h38, 8'h05);
      set_load(24'd1);
      wreg(8'h37, 8'h40);
      tick_once();
      wreg(8'h13, 8'h00);
      wreg(8'h3C, 8'h40);
      check("R3 locked kick ignored", irq_req, 1);
      rreg(8'h3C, d); check("R3 locked read status", d, 8'h40);
      wreg(8'h39, 8'h77);
      rreg(8'h39, d); check("R3 locked load read", d, 8'h01);
      wreg(8'h13, 8'hC5);
      wreg(8'h3C, 8'h40);
      check("R2 reopened kick works", irq_req, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule